// File: doc/BRIEF.md
# Bit-Slip Word Aligner with Boundary Reporting

This block sits behind a deserializer and turns a raw parallel bit stream into aligned words. A mode input selects 10-bit or 20-bit words. The receive side joins the previous and the current input word into a window and searches that window for a comma symbol, in either disparity form. Once the comma is seen three times at the same bit offset, that offset becomes the locked slip. From then on every output word has the comma boundary at bit 0.

The applied slip is reported on a 5-bit boundary-select output. The encoding depends on the mode, and each mode has its own value for the not-yet-aligned state. A per-half sync flag shows when alignment has been reached. The transmit side has no search. A 5-bit input sets the slip directly, so the transmit latency stays fixed.

Top module: `bitslip_aligner`

## Requirements
- R1: While reset is asserted, and whenever no alignment is held, rx_bsel_o shows the sentinel: 5'b01111 in 10-bit mode (mode20_i=0) and 5'b11111 in 20-bit mode (mode20_i=1). Reset also clears rx_sync_o, rx_data_o, tx_data_o and the slip.
- R2: A comma at offset k means that window bits [k+9:k] equal 10'h0FA or 10'h305. The window is {cur, prev} (40 bits, k in 0..19) in 20-bit mode and {cur[9:0], prev[9:0]} (k in 0..9) in 10-bit mode. If several offsets match in one cycle, the lowest one wins.
- R3: Alignment locks on the clock edge of the third comma detection at the same offset. Cycles with no comma leave the count unchanged. A comma at a different offset restarts the count at one.
- R4: In 10-bit mode, once locked, rx_bsel_o equals the slip (0..9).
- R5: In 20-bit mode, once locked, rx_bsel_o equals 19 minus the slip.
- R6: rx_sync_o[0] is high while locked, in either mode. rx_sync_o[1] is high only while locked in 20-bit mode.
- R7: While locked, commas at any other offset do not change the slip or rx_bsel_o.
- R8: A resync_i pulse clears the lock, the slip and rx_sync_o on the next edge, and the search starts again.
- R9: rx_data_o is registered. It equals the window bits [slip+W-1:slip], using the slip held at that edge, with W = 20 or 10. In 10-bit mode bits [19:10] are zero.
- R10: tx_data_o is registered. It equals the transmit window (built as in R2 from tx_data_i) bits [s+W-1:s], where s is tx_bsel_i clamped to W-1. In 10-bit mode bits [19:10] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode20_i | input | 1 | 1 selects 20-bit words, 0 selects 10-bit words |
| resync_i | input | 1 | Drops the lock and restarts the comma search |
| rx_data_i | input | 20 | Raw deserialized word, first bit received at bit 0 |
| rx_data_o | output | 20 | Aligned receive word |
| rx_bsel_o | output | 5 | Reported receive slip, or the sentinel |
| rx_sync_o | output | 2 | Sync flag for each 10-bit half |
| tx_bsel_i | input | 5 | Fixed transmit slip |
| tx_data_i | input | 20 | Transmit word before the slip |
| tx_data_o | output | 20 | Transmit word after the slip |

## Verification
The bench locks on commas placed at offset 0, at the top offset of each mode, and at offsets that straddle the two input words. If the window were built in the wrong order, the design would lock at a wrong offset or never lock. If the 20-bit encoding were taken from the 10-bit one, it would report 0 or 5 where 19 or 14 is due. A count sequence broken by a different offset catches a counter that does not restart, or one that locks after two hits. Commas at a new offset after lock, and a resync, catch a lock that drifts or one that keeps stale state. Out-of-range transmit slips catch a missing clamp, which would read beyond the window.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
  localparam int SYM_W = 10;
  localparam logic [SYM_W-1:0] COMMA_A = 10'h0FA;
  localparam logic [SYM_W-1:0] COMMA_B = 10'h305;

  function automatic logic is_comma(logic [SYM_W-1:0] s);
    return (s == COMMA_A) || (s == COMMA_B);
  endfunction
endpackage

// File: rtl/bitslip_scan.sv
module bitslip_scan
  import bitslip_pkg::*;
#(
  parameter int DW = 20,
  parameter int OW = 5
) (
  input  logic            mode20_i,
  input  logic [2*DW-1:0] win_i,
  output logic            found_o,
  output logic [OW-1:0]   off_o
);
  logic [DW-1:0] hit;

  for (genvar k = 0; k < DW; k++) begin : g_off
    localparam bit LOW_OFF = (k < SYM_W);
    assign hit[k] = is_comma(win_i[k +: SYM_W]) && (mode20_i || LOW_OFF);
  end

  // lowest offset wins
  always_comb begin
    off_o = '0;
    for (int k = DW - 1; k >= 0; k--) begin
      if (hit[k]) off_o = OW'(k);
    end
  end

  assign found_o = |hit;

  always_comb begin
    if (found_o && !mode20_i) begin
      assert_off_narrow_R2: assert (off_o < OW'(SYM_W));
    end
  end
endmodule

// File: rtl/bitslip_lock.sv
module bitslip_lock #(
  parameter int DW       = 20,
  parameter int BSEL_W   = 5,
  parameter int LOCK_CNT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode20_i,
  input  logic              resync_i,
  input  logic              found_i,
  input  logic [BSEL_W-1:0] off_i,
  output logic              locked_o,
  output logic [BSEL_W-1:0] slip_o,
  output logic [BSEL_W-1:0] bsel_o
);
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam logic [BSEL_W-1:0] SENT_NARROW = BSEL_W'((1 << (BSEL_W - 1)) - 1);
  localparam logic [BSEL_W-1:0] SENT_WIDE   = '1;
  localparam logic [BSEL_W-1:0] TOP_OFF     = BSEL_W'(DW - 1);

  logic [BSEL_W-1:0] cand_q, slip_q;
  logic [CW-1:0]     cnt_q, cnt_nxt;
  logic              locked_q, same_off;

  assign same_off = (cnt_q != '0) && (off_i == cand_q);
  assign cnt_nxt  = same_off ? cnt_q + CW'(1) : CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q   <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
      slip_q   <= '0;
    end else if (resync_i) begin
      cand_q   <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
      slip_q   <= '0;
    end else if (!locked_q && found_i) begin
      cand_q <= off_i;
      cnt_q  <= cnt_nxt;
      if (cnt_nxt == CW'(LOCK_CNT)) begin
        locked_q <= 1'b1;
        slip_q   <= off_i;
      end
    end
  end

  always_comb begin
    if (!locked_q)     bsel_o = mode20_i ? SENT_WIDE : SENT_NARROW;
    else if (mode20_i) bsel_o = TOP_OFF - slip_q;
    else               bsel_o = slip_q;
  end

  assign locked_o = locked_q;
  assign slip_o   = slip_q;

  assert_lock_on_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(found_i) && slip_q == $past(off_i)));

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !resync_i) |=> (locked_q && $stable(slip_q)));

  assert_resync_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (!locked_o && slip_o == '0));

  assert_wide_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && mode20_i) |-> (bsel_o <= TOP_OFF));
endmodule

// File: rtl/bitslip_sel.sv
module bitslip_sel
  import bitslip_pkg::*;
#(
  parameter int DW = 20,
  parameter int SW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode20_i,
  input  logic [2*DW-1:0] win_i,
  input  logic [SW-1:0]   slip_i,
  output logic [DW-1:0]   data_o
);
  localparam int IW = $clog2(2 * DW);
  localparam logic [SW-1:0] LIM_WIDE   = SW'(DW - 1);
  localparam logic [SW-1:0] LIM_NARROW = SW'(SYM_W - 1);
  localparam logic [DW-1:0] LOW_MASK   = DW'((1 << SYM_W) - 1);

  logic [SW-1:0] lim, eff;
  logic [IW-1:0] idx;
  logic [DW-1:0] pick;

  assign lim  = mode20_i ? LIM_WIDE : LIM_NARROW;
  assign eff  = (slip_i > lim) ? lim : slip_i;
  assign idx  = IW'(eff);
  assign pick = win_i[idx +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= mode20_i ? pick : (pick & LOW_MASK);
  end

  assert_narrow_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode20_i |=> (data_o[DW-1:SYM_W] == '0));
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
  import bitslip_pkg::*;
#(
  parameter int DW       = 20,
  parameter int BSEL_W   = 5,
  parameter int LOCK_CNT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode20_i,
  input  logic              resync_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic [DW-1:0]     rx_data_o,
  output logic [BSEL_W-1:0] rx_bsel_o,
  output logic [DW/SYM_W-1:0] rx_sync_o,
  input  logic [BSEL_W-1:0] tx_bsel_i,
  input  logic [DW-1:0]     tx_data_i,
  output logic [DW-1:0]     tx_data_o
);
  localparam int WIN_W = 2 * DW;
  localparam int NHALF = DW / SYM_W;

  logic [DW-1:0]     rx_prev_q, tx_prev_q;
  logic [WIN_W-1:0]  rx_win, tx_win;
  logic              found, locked;
  logic [BSEL_W-1:0] off, slip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_prev_q <= '0;
      tx_prev_q <= '0;
    end else begin
      rx_prev_q <= rx_data_i;
      tx_prev_q <= tx_data_i;
    end
  end

  // narrow mode uses only the low symbol of each word
  always_comb begin
    rx_win = '0;
    tx_win = '0;
    if (mode20_i) begin
      rx_win = {rx_data_i, rx_prev_q};
      tx_win = {tx_data_i, tx_prev_q};
    end else begin
      rx_win[2*SYM_W-1:0] = {rx_data_i[SYM_W-1:0], rx_prev_q[SYM_W-1:0]};
      tx_win[2*SYM_W-1:0] = {tx_data_i[SYM_W-1:0], tx_prev_q[SYM_W-1:0]};
    end
  end

  bitslip_scan #(.DW(DW), .OW(BSEL_W)) u_scan (
    .mode20_i (mode20_i),
    .win_i    (rx_win),
    .found_o  (found),
    .off_o    (off)
  );

  bitslip_lock #(.DW(DW), .BSEL_W(BSEL_W), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode20_i (mode20_i),
    .resync_i (resync_i),
    .found_i  (found),
    .off_i    (off),
    .locked_o (locked),
    .slip_o   (slip),
    .bsel_o   (rx_bsel_o)
  );

  bitslip_sel #(.DW(DW), .SW(BSEL_W)) u_rx_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode20_i (mode20_i),
    .win_i    (rx_win),
    .slip_i   (slip),
    .data_o   (rx_data_o)
  );

  bitslip_sel #(.DW(DW), .SW(BSEL_W)) u_tx_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode20_i (mode20_i),
    .win_i    (tx_win),
    .slip_i   (tx_bsel_i),
    .data_o   (tx_data_o)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_sync
    if (h == 0) begin : g_base
      assign rx_sync_o[h] = locked;
    end else begin : g_upper
      assign rx_sync_o[h] = locked & mode20_i;
    end
  end

  assert_sync_reports_slip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sync_o[0] |-> (rx_bsel_o <= BSEL_W'(DW - 1)));
endmodule

// File: tb/bitslip_aligner_bench.sv
`timescale 1ns/1ps
module bitslip_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        resync = 1'b0;
  logic [19:0] rx_in = '0;
  logic [19:0] tx_in = '0;
  logic [4:0]  tx_bsel = '0;
  logic [19:0] rx_out, tx_out;
  logic [4:0]  bsel;
  logic [1:0]  sync;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [19:0] m_rx_prev = '0, m_tx_prev = '0, m_rx_out = '0, m_tx_out = '0;
  int m_cand = 0, m_cnt = 0, m_slip = 0;
  bit m_locked = 0;

  always #2.5 clk = ~clk;

  bitslip_aligner u_bitslip_aligner (
    .clk_i(clk), .rst_ni(rst_n), .mode20_i(mode), .resync_i(resync),
    .rx_data_i(rx_in), .rx_data_o(rx_out), .rx_bsel_o(bsel), .rx_sync_o(sync),
    .tx_bsel_i(tx_bsel), .tx_data_i(tx_in), .tx_data_o(tx_out)
  );

  function automatic logic [39:0] mk_win(logic m20, logic [19:0] cur, logic [19:0] prev);
    return m20 ? {cur, prev} : {20'b0, cur[9:0], prev[9:0]};
  endfunction

  function automatic int scan(logic m20, logic [39:0] w);
    int lim = m20 ? 20 : 10;
    for (int k = 0; k < lim; k++)
      if (w[k +: 10] == 10'h0FA || w[k +: 10] == 10'h305) return k;
    return -1;
  endfunction

  function automatic logic [19:0] pick(logic m20, logic [39:0] w, int s);
    int lim = m20 ? 19 : 9;
    logic [19:0] r;
    if (s > lim) s = lim;
    r = w[s +: 20];
    if (!m20) r[19:10] = '0;
    return r;
  endfunction

  function automatic logic [4:0] exp_bsel();
    if (!m_locked) return mode ? 5'd31 : 5'd15;
    return mode ? 5'(19 - m_slip) : 5'(m_slip);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [39:0] w, tw;
    int k;
    w = mk_win(mode, rx_in, m_rx_prev);
    m_rx_out = pick(mode, w, m_slip);
    k = scan(mode, w);
    if (resync) begin
      m_cand = 0; m_cnt = 0; m_locked = 0; m_slip = 0;
    end else if (!m_locked && k >= 0) begin
      if (m_cnt > 0 && k == m_cand) m_cnt++;
      else begin m_cand = k; m_cnt = 1; end
      if (m_cnt == 3) begin m_locked = 1; m_slip = k; end
    end
    tw = mk_win(mode, tx_in, m_tx_prev);
    m_tx_out = pick(mode, tw, int'(tx_bsel));
    m_rx_prev = rx_in;
    m_tx_prev = tx_in;
  endtask

  task automatic compare();
    chk(m_locked ? (mode ? "R5 bsel" : "R4 bsel") : "R1 sentinel", 32'(bsel), 32'(exp_bsel()));
    chk("R6 sync", 32'(sync), {30'b0, m_locked & mode, m_locked});
    chk("R9 rx_data", 32'(rx_out), 32'(m_rx_out));
    chk("R10 tx_data", 32'(tx_out), 32'(m_tx_out));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic do_resync();
    resync = 1'b1; step(); resync = 1'b0;
  endtask

  // comma at window offset k over two words; leaves rx_in at zero
  task automatic send(int k, bit pol);
    logic [9:0]  c = pol ? 10'h305 : 10'h0FA;
    logic [39:0] w40;
    logic [19:0] w20;
    if (mode) begin
      w40 = 40'(c) << k;
      rx_in = w40[19:0];  step();
      rx_in = w40[39:20]; step();
    end else begin
      w20 = 20'(c) << k;
      rx_in = {10'b0, w20[9:0]};  step();
      rx_in = {10'b0, w20[19:10]}; step();
    end
    rx_in = '0;
  endtask

  task automatic gap();
    rx_in = '0; step();
  endtask

  task automatic send_g(int k, bit pol);
    send(k, pol); gap();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k_rand;
    void'($urandom(32'd5150));
    // reset state
    @(negedge clk);
    chk("R1 reset bsel narrow", 32'(bsel), 32'd15);
    chk("R1 reset sync", 32'(sync), 32'd0);
    chk("R1 reset rx", 32'(rx_out), 32'd0);
    chk("R1 reset tx", 32'(tx_out), 32'd0);
    mode = 1'b1;
    #1;
    chk("R1 reset bsel wide", 32'(bsel), 32'd31);
    mode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    gap(); gap();

    // R3: two hits are not enough
    send_g(7, 0); send_g(7, 1);
    chk("R3 two hits", 32'(sync), 32'd0);
    send(7, 0);
    chk("R4 slip 7", 32'(bsel), 32'd7);
    chk("R6 narrow sync", 32'(sync), 32'd1);
    gap();
    // R7: other offsets ignored while locked
    send_g(2, 0); send_g(2, 0); send_g(2, 1);
    chk("R7 hold", 32'(bsel), 32'd7);
    // R8
    do_resync();
    chk("R8 bsel", 32'(bsel), 32'd15);
    chk("R8 sync", 32'(sync), 32'd0);
    // R3: different offset restarts count
    send_g(3, 0); send_g(3, 1); send_g(5, 0); send_g(3, 0); send_g(3, 1);
    chk("R3 restart", 32'(sync), 32'd0);
    send_g(3, 1);
    chk("R2 R3 lock at 3", 32'(bsel), 32'd3);
    // R9: comma lands at bit 0
    send(3, 0);
    chk("R9 aligned comma", 32'(rx_out), 32'h0FA);
    gap();

    // wide mode
    mode = 1'b1;
    do_resync();
    chk("R1 wide sentinel", 32'(bsel), 32'd31);
    send_g(5, 0); send_g(5, 1); send_g(5, 0);
    chk("R5 slip 5", 32'(bsel), 32'd14);
    chk("R6 wide sync", 32'(sync), 32'd3);
    send(5, 1);
    chk("R9 wide aligned", 32'(rx_out), 32'h00305);
    gap();
    do_resync();
    send_g(0, 1); send_g(0, 1); send_g(0, 0);
    chk("R5 slip 0", 32'(bsel), 32'd19);
    do_resync();
    send_g(19, 0); send_g(19, 1); send_g(19, 0);
    chk("R5 slip 19", 32'(bsel), 32'd0);

    // R10 transmit slip and clamp
    mode = 1'b0; do_resync();
    tx_bsel = 5'd25; tx_in = 20'h00001; step(); step();
    chk("R10 narrow clamp", 32'(tx_out), 32'h00002);
    mode = 1'b1; do_resync();
    tx_bsel = 5'd31; step(); step();
    chk("R10 wide clamp", 32'(tx_out), 32'h00002);
    tx_bsel = 5'd0; tx_in = 20'hABCDE; step(); step();
    chk("R10 zero slip", 32'(tx_out), 32'hABCDE);

    // random phase
    k_rand = 4;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 100 == 0) begin
        mode = ~mode; resync = 1'b1;
        k_rand = int'($urandom % (mode ? 20 : 10));
      end else if ($urandom % 150 == 0) begin
        resync = 1'b1;
      end
      if ($urandom % 20 == 0) tx_bsel = 5'($urandom);
      tx_in = 20'($urandom);
      if ($urandom % 4 == 0 && !resync) begin
        send(k_rand, 1'($urandom));
      end else begin
        rx_in = 20'($urandom & $urandom & $urandom);
        step();
        resync = 1'b0;
      end
      if ($urandom % 40 == 0) k_rand = int'($urandom % (mode ? 20 : 10));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule